// File: doc/BRIEF.md
# Iterative Compound Interest Engine

This block works out the future value of a sum after a number of years of yearly compounding. The present value arrives in hundredths, so an entry of 500 stands for 5.00. The rate is a whole percentage and the year count runs from 1 to 63. The result is reported as four base-100 digits, ready for a display stage that shows two decimal places per digit.

The arithmetic is a loop. Each year the running value is multiplied by (100 + rate), divided by 100, and any fraction is dropped before the next year begins. Because of this truncation, 5.00 at 10 % over five years ends at 804 hundredths. A closed-form evaluation would give 805.

Once the year count reaches zero, the value is split into digits, least significant first, over four cycles. A computation is launched by a low-to-high transition on `start`. The done flag then holds the result until the next launch.

Top module: `compound_interest_engine`

## Requirements
- R1: While `rst` is high and after it is released, `done` is low and all four digit outputs are 0 until a computation finishes.
- R2: A computation is launched only at a rising clock edge where `start` is 1 and was 0 at the previous edge. A `start` held high since reset launches nothing until it has been seen low.
- R3: The operands are captured at launch. Then, for each of the `years` years, the value becomes floor(value × (100 + `rate_pct`) / 100). The value starts from `pv_hund`. For example, 10000 at 10 % over 5 years gives 16105.
- R4: The final value v is reported as base-100 digits. `res_d0` = v mod 100, `res_d1` = (v/100) mod 100, `res_d2` = (v/10^4) mod 100 and `res_d3` = (v/10^6) mod 100. A value above 99,999,999 therefore shows v mod 10^8.
- R5: `done` rises exactly `years` + 5 clock edges after the launching edge.
- R6: `done` is low from the edge after a launch until the result is ready. It then stays high, with the digit outputs unchanged, until the next launch.
- R7: While a computation is in progress, further `start` transitions and changes on `pv_hund`, `rate_pct` and `years` have no effect on the result or its timing.
- R8: No intermediate value overflows. The largest 27-bit present value at 99 % for one year yields 267,093,276, which is shown as digits 67, 9, 32, 76.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset |
| clk | input | 1 | Clock |
| start | input | 1 | Launch request; a 0-to-1 transition starts a computation |
| pv_hund | input | 27 | Present value in hundredths |
| rate_pct | input | 7 | Yearly rate in percent (1 to 99) |
| years | input | 6 | Number of compounding years (1 to 63) |
| res_d3 | output | 7 | Most significant base-100 digit |
| res_d2 | output | 7 | Third base-100 digit |
| res_d1 | output | 7 | Second base-100 digit |
| res_d0 | output | 7 | Least significant base-100 digit |
| done | output | 1 | Result valid; high until the next launch |

## Verification
A year counter that decrements wrongly shows up in two ways: `done` arrives at a different edge than `years` + 5, and the digits reflect the wrong number of compounding passes. Both can be seen on the very run that goes wrong. A fault in the per-year multiply or divide changes the digits at the end of the same run, and the truncation cases make an off-by-one rounding visible. A digit split that selects the wrong register, or that keeps its remainder badly, shows as swapped or stale digits once `done` rises. A launch detector that reacts to a held or busy `start` shows as a premature drop of `done`, or as a changed result, within a few cycles of the stray edge.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int unsigned RADIX = 100;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_STEP  = 2'd1,
    PH_SPLIT = 2'd2,
    PH_FIN   = 2'd3
  } phase_e;
endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
#(
  parameter int NDIG  = 4,
  parameter int IDX_W = (NDIG > 1) ? $clog2(NDIG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             yrs_zero,
  output logic             load,
  output logic             step,
  output logic             split_en,
  output logic             split_first,
  output logic [IDX_W-1:0] split_idx,
  output logic             done
);
  phase_e           ph_q;
  logic             start_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             launch;

  assign launch = start & ~start_q & ((ph_q == PH_IDLE) || (ph_q == PH_FIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      start_q <= 1'b1;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      start_q <= start;
      unique case (ph_q)
        PH_IDLE, PH_FIN: begin
          if (launch) begin
            ph_q   <= PH_STEP;
            done_q <= 1'b0;
          end
        end
        PH_STEP: begin
          if (yrs_zero) begin
            ph_q  <= PH_SPLIT;
            idx_q <= '0;
          end
        end
        PH_SPLIT: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(NDIG - 1)) begin
            ph_q   <= PH_FIN;
            done_q <= 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign load        = launch;
  assign step        = (ph_q == PH_STEP);
  assign split_en    = (ph_q == PH_SPLIT);
  assign split_first = (idx_q == '0);
  assign split_idx   = idx_q;
  assign done        = done_q;

  // R6: a launch drops the result flag on the next edge
  p_launch_clears_done_r6: assert property (@(posedge clk) disable iff (rst)
    launch |=> !done_q);

  // R6: the result flag holds until a launch
  p_done_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (done_q && !launch) |=> done_q);

  // R7: a running computation is never restarted by start
  p_busy_ignores_start_r7: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_STEP) |=> ((ph_q == PH_STEP) || (ph_q == PH_SPLIT)));

  // R5: the flag rises only at the end of the digit split
  p_done_after_split_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> ($past(ph_q) == PH_SPLIT));
endmodule

// File: rtl/cic_compound.sv
module cic_compound
  import cic_pkg::*;
#(
  parameter int VAL_W  = 27,
  parameter int RATE_W = 7,
  parameter int YEAR_W = 6,
  parameter int ACC_W  = VAL_W + 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [VAL_W-1:0]  pv,
  input  logic [RATE_W-1:0] rate,
  input  logic [YEAR_W-1:0] years,
  output logic [ACC_W-1:0]  acc,
  output logic              yrs_zero
);
  localparam int FAC_W  = RATE_W + 1;
  localparam int PROD_W = ACC_W + FAC_W;

  logic [ACC_W-1:0]  acc_q;
  logic [FAC_W-1:0]  fac_q;
  logic [YEAR_W-1:0] yrs_q;
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  acc_nxt;

  always_comb begin
    prod    = PROD_W'(acc_q) * PROD_W'(fac_q);
    acc_nxt = ACC_W'(prod / PROD_W'(RADIX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      fac_q <= '0;
      yrs_q <= '0;
    end else if (load) begin
      acc_q <= ACC_W'(pv);
      fac_q <= FAC_W'(rate) + FAC_W'(RADIX);
      yrs_q <= years;
    end else if (step && (yrs_q != '0)) begin
      acc_q <= acc_nxt;
      yrs_q <= yrs_q - 1'b1;
    end
  end

  assign acc      = acc_q;
  assign yrs_zero = (yrs_q == '0);

  // R3: one year is consumed per compounding pass
  p_year_count_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !load && (yrs_q != '0)) |=> (yrs_q == $past(yrs_q) - 1'b1));

  // R8: a factor of at least 100 never shrinks the value
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (step && !load && (yrs_q != '0) && (acc_q < ACC_W'(1) << (ACC_W - 2))) |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/cic_base100.sv
module cic_base100
  import cic_pkg::*;
#(
  parameter int ACC_W = 35,
  parameter int NDIG  = 4,
  parameter int DIG_W = 7,
  parameter int IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  first,
  input  logic [IDX_W-1:0]      idx,
  input  logic [ACC_W-1:0]      seed,
  output logic [NDIG*DIG_W-1:0] digits
);
  logic [ACC_W-1:0] rem_q;
  logic [ACC_W-1:0] src;
  logic [ACC_W-1:0] quo;
  logic [DIG_W-1:0] dig_now;

  always_comb begin
    src     = first ? seed : rem_q;
    quo     = src / ACC_W'(RADIX);
    dig_now = DIG_W'(src - quo * ACC_W'(RADIX));
  end

  always_ff @(posedge clk) begin
    if (rst)     rem_q <= '0;
    else if (en) rem_q <= quo;
  end

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [DIG_W-1:0] d_q;
    always_ff @(posedge clk) begin
      if (rst)                          d_q <= '0;
      else if (en && (idx == IDX_W'(g))) d_q <= dig_now;
    end
    assign digits[g*DIG_W +: DIG_W] = d_q;

    // R4: every stored digit is a legal base-100 digit
    p_digit_range_r4: assert property (@(posedge clk) disable iff (rst)
      d_q < DIG_W'(RADIX));
  end

  // R6: digits only move during the split phase
  p_digits_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(digits));
endmodule

// File: rtl/compound_interest_engine.sv
module compound_interest_engine #(
  parameter int VAL_W  = 27,
  parameter int RATE_W = 7,
  parameter int YEAR_W = 6,
  parameter int DIG_W  = 7
) (
  input  logic              rst,
  input  logic              clk,
  input  logic              start,
  input  logic [VAL_W-1:0]  pv_hund,
  input  logic [RATE_W-1:0] rate_pct,
  input  logic [YEAR_W-1:0] years,
  output logic [DIG_W-1:0]  res_d3,
  output logic [DIG_W-1:0]  res_d2,
  output logic [DIG_W-1:0]  res_d1,
  output logic [DIG_W-1:0]  res_d0,
  output logic              done
);
  localparam int NDIG  = 4;
  localparam int IDX_W = $clog2(NDIG);
  localparam int ACC_W = VAL_W + 8;

  logic             load, step, split_en, split_first, yrs_zero;
  logic [IDX_W-1:0] split_idx;
  logic [ACC_W-1:0] acc;
  logic [NDIG*DIG_W-1:0] digits;

  cic_ctrl #(.NDIG(NDIG), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .yrs_zero(yrs_zero),
    .load(load), .step(step), .split_en(split_en),
    .split_first(split_first), .split_idx(split_idx), .done(done)
  );

  cic_compound #(.VAL_W(VAL_W), .RATE_W(RATE_W), .YEAR_W(YEAR_W), .ACC_W(ACC_W)) u_comp (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .pv(pv_hund), .rate(rate_pct), .years(years),
    .acc(acc), .yrs_zero(yrs_zero)
  );

  cic_base100 #(.ACC_W(ACC_W), .NDIG(NDIG), .DIG_W(DIG_W), .IDX_W(IDX_W)) u_split (
    .clk(clk), .rst(rst), .en(split_en), .first(split_first),
    .idx(split_idx), .seed(acc), .digits(digits)
  );

  assign res_d0 = digits[0*DIG_W +: DIG_W];
  assign res_d1 = digits[1*DIG_W +: DIG_W];
  assign res_d2 = digits[2*DIG_W +: DIG_W];
  assign res_d3 = digits[3*DIG_W +: DIG_W];
endmodule

// File: tb/compound_interest_engine_tb.sv
module compound_interest_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [26:0] pv_hund = '0;
  logic [6:0]  rate_pct = '0;
  logic [5:0]  years = '0;
  logic [6:0]  res_d3, res_d2, res_d1, res_d0;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  compound_interest_engine u_dut (
    .rst(rst), .clk(clk), .start(start), .pv_hund(pv_hund),
    .rate_pct(rate_pct), .years(years), .res_d3(res_d3), .res_d2(res_d2),
    .res_d1(res_d1), .res_d0(res_d0), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint model(input longint pv, input longint r, input int y);
    longint v = pv;
    for (int i = 0; i < y; i++) v = ((v * (100 + r)) / 100) & ((64'd1 << 35) - 1);
    return v % 100000000;
  endfunction

  function automatic longint shown();
    return longint'(res_d3) * 1000000 + longint'(res_d2) * 10000
         + longint'(res_d1) * 100 + longint'(res_d0);
  endfunction

  task automatic run_case(input longint pv, input longint r, input int y,
                          input longint exp_v, input bit poke);
    int k;
    @(negedge clk);
    start = 1'b0; pv_hund = 27'(pv); rate_pct = 7'(r); years = 6'(y);
    @(negedge clk);
    start = 1'b1;
    k = -1;
    do begin
      @(negedge clk);
      k++;
      if (k == 0) check(!done, "R6 done low after launch", longint'(done), 0);
      if (poke && k == 2) begin
        start = 1'b0; pv_hund = 27'd1; rate_pct = 7'd50; years = 6'd3;
      end
      if (poke && k == 3) start = 1'b1;
    end while (!done && k < 300);
    check(k == y + 5, poke ? "R7 latency with busy start" : "R5 latency", k, y + 5);
    check(shown() == exp_v, poke ? "R7 result with busy start" : "R3/R4 digits", shown(), exp_v);
  endtask

  task automatic t_reset();
    check(!done && shown() == 0, "R1 reset state", shown() + (done ? 1 : 0), 0);
  endtask

  task automatic t_held_start();
    @(negedge clk); rst = 1'b1; start = 1'b1; pv_hund = 27'd777; rate_pct = 7'd5; years = 6'd2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check(!done, "R2 held start no launch", longint'(done), 0);
    check(shown() == 0, "R1 digits zero after reset", shown(), 0);
    start = 1'b0;
    repeat (5) @(negedge clk);
    check(!done, "R2 falling start no launch", longint'(done), 0);
  endtask

  task automatic t_hold();
    longint v = shown();
    @(negedge clk); pv_hund = 27'd4242; rate_pct = 7'd77; years = 6'd9;
    repeat (12) @(negedge clk);
    check(done, "R6 done holds", longint'(done), 1);
    check(shown() == v, "R6 digits hold", shown(), v);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    run_case(10000, 10, 5, 16105, 1'b0);
    check(res_d3 == 0 && res_d2 == 1 && res_d1 == 61 && res_d0 == 5, "R4 digit order",
          shown(), 16105);
    run_case(500, 10, 5, 804, 1'b0);
    check(shown() == model(500, 10, 5), "R3 truncation per year", shown(), model(500, 10, 5));
    t_hold();
    run_case(12345, 7, 1, model(12345, 7, 1), 1'b0);
    run_case(1000, 1, 63, model(1000, 1, 63), 1'b0);
    run_case(1000, 99, 10, model(1000, 99, 10), 1'b0);
    run_case(100000000, 1, 1, 1000000, 1'b0);
    run_case(134217727, 99, 1, 67093276, 1'b0);
    check(res_d3 == 67 && res_d2 == 9 && res_d1 == 32 && res_d0 == 76, "R8 wide product",
          shown(), 67093276);
    run_case(2500, 12, 20, model(2500, 12, 20), 1'b1);
    t_held_start();
    run_case(999, 3, 4, model(999, 3, 4), 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule